// File: doc/BRIEF.md
# Arbitrated External Bus Master

This block is a single-transaction master for a shared, multiplexed 32-bit address/data bus with active-low strobes. An internal client hands it one command at a time: an address, write data, byte enables and a direction. The block raises its request line and waits for an external arbiter to grant the bus. It then runs one read or write cycle with an address strobe, a data strobe, a read/write line and byte enables, returns the read data, and releases the request.

Three stretch counts lengthen the address phase, the data-strobe pulse and the quiet gap before the next request. Each count runs from 0 to 15 clocks and is sampled when a command is accepted. If the arbiter keeps the grant after a cycle, the block parks on the bus and drives every command line to its inactive level. If the grant is withdrawn at any time, the block stops driving on the next clock. An unfinished cycle is then reported to the client as aborted and is never retried.

Every shared output has its own value and its own output enable, which models three-state drive. The address/data lines also have a separate input path.

Top module: `ebm_master`

## Requirements
Cycle numbering: "edge G" is the first rising edge at which `bus_req_n` and `bus_gnt_n` are both sampled low. "Cycle k" is the clock period that starts k edges after G, so cycle 1 starts at edge G itself. A and E are the address and data stretch counts latched at acceptance.
- R1: After reset, `bus_req_n`=1, `cmd_ready`=1 and all output enables are 0. Outside a bus cycle and when not parked, `bus_cmd_oe`, `bus_gack_oe` and `bus_ad_oe` stay 0, including while a request waits for grant.
- R2: In cycle 1, `bus_cmd_oe`=1, `bus_as_n`=`bus_ds_n`=`bus_rw_n`=1, `bus_be_n` is the inverse of the accepted `cmd_be` (bit i enables byte lane i), and `bus_ad_oe`=0.
- R3: `bus_gack_n` is low from cycle 3 through the last cycle in which `bus_ds_n` is low, and high otherwise. `bus_gack_oe` equals `bus_cmd_oe`.
- R4: The address is driven on `bus_ad_out` with `bus_ad_oe`=1 and `bus_as_n`=1 in cycles 2 to 2+A. In cycle 3+A, `bus_as_n` goes low and the address is still driven.
- R5: For a write, `bus_rw_n`=0 and the write data is driven in cycle 4+A, one cycle before `bus_ds_n` falls, and both are held through the hold cycle. For a read, `bus_rw_n` stays 1 and `bus_ad_oe`=0 from the data strobe onward.
- R6: `bus_ds_n` is low for 1+E cycles. For a read, `bus_ad_in` is captured at the edge where `bus_ds_n` rises. In the next cycle (the hold cycle), `done`=1, `done_abort`=0 and `rdata` holds the captured word.
- R7: In the hold cycle, `bus_ds_n` and `bus_gack_n` are high, while `bus_as_n`, `bus_be_n`, `bus_rw_n` and any write data stay driven.
- R8: In the cycle after the hold cycle, `bus_req_n`=1. While grant stays low, the block is parked: `bus_cmd_oe`=1, strobes high, `bus_be_n` all ones, `bus_ad_oe`=0. This also holds while a new request waits. One cycle after `bus_gnt_n` is sampled high, `bus_cmd_oe` and `bus_gack_oe` are 0.
- R9: After a cycle ends, `bus_req_n` stays high for exactly 1+B cycles before the next request, where B is the gap count latched with the finished command. `cmd_ready` is 1 only when the block is idle and the gap has expired.
- R10: If `bus_gnt_n` is sampled high during a bus cycle, in the next cycle all output enables are 0 and `bus_req_n`=1. If this happens before the hold cycle, `done`=1 and `done_abort`=1 for one cycle. No further request follows without a new command.
- R11: Changing the stretch-count inputs after a command is accepted has no effect on that command's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Client presents a command |
| cmd_ready | output | 1 | Command accepted at this edge when valid |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | DW | Bus address |
| cmd_wdata | input | DW | Write data |
| cmd_be | input | DW/8 | Active-high byte enables |
| cfg_alapse | input | LW | Extra address-phase clocks |
| cfg_elapse | input | LW | Extra data-strobe clocks |
| cfg_blapse | input | LW | Extra request-gap clocks |
| done | output | 1 | One-cycle completion pulse |
| done_abort | output | 1 | Completion was an abort |
| rdata | output | DW | Captured read data |
| bus_req_n | output | 1 | Bus request, active low |
| bus_gnt_n | input | 1 | Bus grant from arbiter, active low |
| bus_gack_n | output | 1 | Grant acknowledge, active low |
| bus_gack_oe | output | 1 | Drive enable for grant acknowledge |
| bus_cmd_oe | output | 1 | Drive enable for strobes, direction and byte enables |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_ds_n | output | 1 | Data strobe, active low |
| bus_rw_n | output | 1 | Direction, low = write |
| bus_be_n | output | DW/8 | Byte enables, active low |
| bus_ad_out | output | DW | Address/data output value |
| bus_ad_oe | output | 1 | Drive enable for address/data |
| bus_ad_in | input | DW | Address/data input |

## Verification
A wrong phase state shows at the bus pins in the very next cycle. A strobe, direction or enable then differs from the cycle-indexed expectation, so the bench compares the whole pin set every cycle from grant through parking. A stale stretch counter shows as a phase that is one or more cycles too long or too short: a late falling address strobe, a wrong data-strobe width, or a wrong request-gap length. Each of these is visible within at most 16 cycles. A faulty parked or abort state shows one cycle after the grant changes, as enables that are still driven or a missing aborted completion.

// File: rtl/ebm_pkg.sv
package ebm_pkg;

    parameter int unsigned EBM_DATA_W  = 32;
    parameter int unsigned EBM_LAPSE_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_CMD,
        ST_ADDR,
        ST_ASL,
        ST_WSET,
        ST_DATA,
        ST_HOLD
    } ebm_state_e;

    // Control pin bundle produced by the drive decoder
    typedef struct packed {
        logic req_n;
        logic gack_n;
        logic gack_oe;
        logic cmd_oe;
        logic as_n;
        logic ds_n;
        logic rw_n;
        logic ad_oe;
        logic ad_is_addr;
    } ebm_ctl_t;

    function automatic logic st_on_bus(ebm_state_e s);
        return s inside {ST_CMD, ST_ADDR, ST_ASL, ST_WSET, ST_DATA, ST_HOLD};
    endfunction

    function automatic logic st_strobed(ebm_state_e s);
        return s inside {ST_ASL, ST_WSET, ST_DATA, ST_HOLD};
    endfunction

endpackage

// File: rtl/ebm_lapse_cnt.sv
module ebm_lapse_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/ebm_drive.sv
module ebm_drive
    import ebm_pkg::*;
#(
    parameter int DW  = EBM_DATA_W,
    parameter int BEW = DW / 8
) (
    input  ebm_state_e     state,
    input  logic           parked,
    input  logic           gack_on,
    input  logic           wr,
    input  logic [DW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    input  logic [BEW-1:0] be,
    output ebm_ctl_t       ctl,
    output logic [BEW-1:0] be_n,
    output logic [DW-1:0]  ad_out
);
    logic on_bus;
    logic wr_phase;

    always_comb begin
        on_bus   = st_on_bus(state);
        wr_phase = wr && (state inside {ST_WSET, ST_DATA, ST_HOLD});

        ctl.req_n      = (state == ST_IDLE);
        ctl.cmd_oe     = on_bus || parked;
        ctl.gack_oe    = on_bus || parked;
        ctl.gack_n     = !gack_on;
        ctl.as_n       = !st_strobed(state);
        ctl.ds_n       = (state != ST_DATA);
        ctl.rw_n       = !wr_phase;
        ctl.ad_is_addr = (state inside {ST_ADDR, ST_ASL});
        ctl.ad_oe      = ctl.ad_is_addr || wr_phase;

        be_n   = on_bus ? ~be : '1;
        ad_out = ctl.ad_is_addr ? addr : wdata;
    end
endmodule

// File: rtl/ebm_master.sv
module ebm_master
    import ebm_pkg::*;
#(
    parameter int DW = EBM_DATA_W,
    parameter int LW = EBM_LAPSE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [DW-1:0]     cmd_addr,
    input  logic [DW-1:0]     cmd_wdata,
    input  logic [DW/8-1:0]   cmd_be,
    input  logic [LW-1:0]     cfg_alapse,
    input  logic [LW-1:0]     cfg_elapse,
    input  logic [LW-1:0]     cfg_blapse,
    output logic              done,
    output logic              done_abort,
    output logic [DW-1:0]     rdata,
    output logic              bus_req_n,
    input  logic              bus_gnt_n,
    output logic              bus_gack_n,
    output logic              bus_gack_oe,
    output logic              bus_cmd_oe,
    output logic              bus_as_n,
    output logic              bus_ds_n,
    output logic              bus_rw_n,
    output logic [DW/8-1:0]   bus_be_n,
    output logic [DW-1:0]     bus_ad_out,
    output logic              bus_ad_oe,
    input  logic [DW-1:0]     bus_ad_in
);
    localparam int BEW = DW / 8;

    ebm_state_e     state_q;
    logic           parked_q, gack_q, done_q, abt_q;
    logic [DW-1:0]  rdata_q, addr_q, wdata_q;
    logic [BEW-1:0] be_q;
    logic           wr_q;
    logic [LW-1:0]  alap_q, elap_q, blap_q;

    logic           grant, on_bus, accept;
    logic           ph_load, ph_zero, gap_load, gap_zero;
    logic [LW-1:0]  ph_val;
    ebm_ctl_t       ctl;

    assign grant  = !bus_gnt_n;
    assign on_bus = st_on_bus(state_q);
    assign accept = (state_q == ST_IDLE) && gap_zero && cmd_valid;

    // Phase stretch: loaded entering the address phase and the data strobe
    assign ph_load = (state_q == ST_CMD) || (state_q == ST_WSET) ||
                     (state_q == ST_ASL && !wr_q);
    assign ph_val  = (state_q == ST_CMD) ? alap_q : elap_q;

    // Request gap: loaded when a bus cycle ends, normally or by abort
    assign gap_load = on_bus && (state_q == ST_HOLD || !grant);

    ebm_lapse_cnt #(.W(LW)) u_phase (
        .clk(clk), .rst(rst), .load(ph_load), .load_val(ph_val), .zero(ph_zero)
    );

    ebm_lapse_cnt #(.W(LW)) u_gap (
        .clk(clk), .rst(rst), .load(gap_load), .load_val(blap_q), .zero(gap_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            parked_q <= 1'b0;
            gack_q   <= 1'b0;
            done_q   <= 1'b0;
            abt_q    <= 1'b0;
            rdata_q  <= '0;
            addr_q   <= '0;
            wdata_q  <= '0;
            be_q     <= '0;
            wr_q     <= 1'b0;
            alap_q   <= '0;
            elap_q   <= '0;
            blap_q   <= '0;
        end else begin
            done_q <= 1'b0;
            abt_q  <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    state_q <= ST_REQ;
                    addr_q  <= cmd_addr;
                    wdata_q <= cmd_wdata;
                    be_q    <= cmd_be;
                    wr_q    <= cmd_write;
                    alap_q  <= cfg_alapse;
                    elap_q  <= cfg_elapse;
                    blap_q  <= cfg_blapse;
                end
                ST_REQ:  if (grant) state_q <= ST_CMD;
                ST_CMD:  state_q <= ST_ADDR;
                ST_ADDR: if (ph_zero) state_q <= ST_ASL;
                ST_ASL:  state_q <= wr_q ? ST_WSET : ST_DATA;
                ST_WSET: state_q <= ST_DATA;
                ST_DATA: if (ph_zero) begin
                    state_q <= ST_HOLD;
                    rdata_q <= bus_ad_in;
                    done_q  <= 1'b1;
                end
                ST_HOLD: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase

            // Loss of grant: drop the bus at once, report unless already done
            if (on_bus && !grant) begin
                state_q <= ST_IDLE;
                if (state_q != ST_HOLD) begin
                    done_q <= 1'b1;
                    abt_q  <= 1'b1;
                end
            end

            if (!grant) begin
                parked_q <= 1'b0;
            end else if (state_q == ST_HOLD) begin
                parked_q <= 1'b1;
            end

            gack_q <= grant && ((state_q inside {ST_ADDR, ST_ASL, ST_WSET}) ||
                                (state_q == ST_DATA && !ph_zero));
        end
    end

    ebm_drive #(.DW(DW), .BEW(BEW)) u_drive (
        .state(state_q), .parked(parked_q), .gack_on(gack_q), .wr(wr_q),
        .addr(addr_q), .wdata(wdata_q), .be(be_q),
        .ctl(ctl), .be_n(bus_be_n), .ad_out(bus_ad_out)
    );

    assign cmd_ready   = (state_q == ST_IDLE) && gap_zero;
    assign done        = done_q;
    assign done_abort  = abt_q;
    assign rdata       = rdata_q;
    assign bus_req_n   = ctl.req_n;
    assign bus_gack_n  = ctl.gack_n;
    assign bus_gack_oe = ctl.gack_oe;
    assign bus_cmd_oe  = ctl.cmd_oe;
    assign bus_as_n    = ctl.as_n;
    assign bus_ds_n    = ctl.ds_n;
    assign bus_rw_n    = ctl.rw_n;
    assign bus_ad_oe   = ctl.ad_oe;

    // R1
    undriven_when_released_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req_n && $past(bus_gnt_n)) |-> (!bus_cmd_oe && !bus_ad_oe && !bus_gack_oe));

    // R3
    gack_within_request_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_gack_n |-> (!bus_req_n && bus_gack_oe));

    // R4
    addr_hold_after_as_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_as_n) |-> (bus_ad_oe && bus_ad_out == $past(bus_ad_out)));

    // R5
    wdata_setup_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(bus_ds_n) && !bus_rw_n) |-> $past(!bus_rw_n && bus_ad_oe && bus_ds_n));

    // R6
    done_at_ds_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_ds_n) |-> done);

    // R8
    park_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD && !bus_gnt_n) |=>
            (bus_req_n && bus_cmd_oe && bus_as_n && bus_ds_n && !bus_ad_oe));

    // R10
    abort_release_chk: assert property (@(posedge clk) disable iff (rst)
        (on_bus && bus_gnt_n) |=> (!bus_cmd_oe && !bus_ad_oe && !bus_gack_oe && bus_req_n));
endmodule

// File: tb/tb_ebm_master.sv
`timescale 1ns/1ps
module tb_ebm_master;
    localparam int DW  = 32;
    localparam int LW  = 4;
    localparam int BEW = DW / 8;

    logic clk = 1'b0;
    logic rst;
    logic cmd_valid, cmd_ready, cmd_write;
    logic [DW-1:0] cmd_addr, cmd_wdata, rdata, bus_ad_out, bus_ad_in;
    logic [BEW-1:0] cmd_be, bus_be_n;
    logic [LW-1:0] cfg_alapse, cfg_elapse, cfg_blapse;
    logic done, done_abort;
    logic bus_req_n, bus_gnt_n, bus_gack_n, bus_gack_oe, bus_cmd_oe;
    logic bus_as_n, bus_ds_n, bus_rw_n, bus_ad_oe;

    ebm_master #(.DW(DW), .LW(LW)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .cmd_be(cmd_be), .cfg_alapse(cfg_alapse), .cfg_elapse(cfg_elapse),
        .cfg_blapse(cfg_blapse), .done(done), .done_abort(done_abort),
        .rdata(rdata), .bus_req_n(bus_req_n), .bus_gnt_n(bus_gnt_n),
        .bus_gack_n(bus_gack_n), .bus_gack_oe(bus_gack_oe),
        .bus_cmd_oe(bus_cmd_oe), .bus_as_n(bus_as_n), .bus_ds_n(bus_ds_n),
        .bus_rw_n(bus_rw_n), .bus_be_n(bus_be_n), .bus_ad_out(bus_ad_out),
        .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in)
    );

    always #2 clk = ~clk;

    typedef struct packed {
        logic req_n, gack_n, gack_oe, cmd_oe, as_n, ds_n, rw_n;
        logic [BEW-1:0] be_n;
        logic ad_oe;
        logic [DW-1:0] ad;
        logic dn, abt;
    } obs_t;

    int  checks = 0;
    int  errors = 0;
    int  prev_b = 0;
    bit  chain  = 0;

    function automatic obs_t sample();
        obs_t o;
        o.req_n = bus_req_n;  o.gack_n = bus_gack_n; o.gack_oe = bus_gack_oe;
        o.cmd_oe = bus_cmd_oe; o.as_n = bus_as_n;    o.ds_n = bus_ds_n;
        o.rw_n = bus_rw_n;     o.be_n = bus_be_n;    o.ad_oe = bus_ad_oe;
        o.ad = bus_ad_oe ? bus_ad_out : '0;
        o.dn = done;           o.abt = done_abort;
        return o;
    endfunction

    // Pins released: idle, not parked
    function automatic obs_t released(bit dn);
        obs_t o;
        o = '0;
        o.req_n = 1; o.gack_n = 1; o.as_n = 1; o.ds_n = 1; o.rw_n = 1;
        o.be_n = '1; o.dn = dn; o.abt = dn;
        return o;
    endfunction

    // Expected pins in cycle k after the grant edge (R2..R8)
    function automatic obs_t expect_at(int k, int a, int e, bit wr,
                                       logic [DW-1:0] addr, logic [DW-1:0] wd,
                                       logic [BEW-1:0] be);
        obs_t o;
        int holdk, dstart;
        holdk  = wr ? 6 + a + e : 5 + a + e;
        dstart = wr ? 5 + a : 4 + a;
        o = '0;
        o.req_n = 0; o.gack_n = 1; o.gack_oe = 1; o.cmd_oe = 1;
        o.as_n = 1; o.ds_n = 1; o.rw_n = 1; o.be_n = ~be;
        if (k >= 2 && k <= 3 + a) begin o.ad_oe = 1; o.ad = addr; end
        if (k >= 3 && k <= holdk - 1) o.gack_n = 0;
        if (k >= 3 + a && k <= holdk) o.as_n = 0;
        if (wr && k >= 4 + a && k <= holdk) begin o.rw_n = 0; o.ad_oe = 1; o.ad = wd; end
        if (k >= dstart && k <= holdk - 1) o.ds_n = 0;
        if (k == holdk) o.dn = 1;
        if (k == holdk + 1) begin
            o.req_n = 1; o.as_n = 1; o.rw_n = 1; o.be_n = '1; o.ad_oe = 0; o.ad = '0;
        end
        return o;
    endfunction

    function automatic string phase_tag(int k, int a, int e, bit wr);
        int holdk;
        holdk = wr ? 6 + a + e : 5 + a + e;
        if (k == 1) return "R2";
        if (k <= 3 + a) return "R4 R11";
        if (k == holdk) return "R7";
        if (k == holdk + 1) return "R8";
        if (wr && k == 4 + a) return "R5";
        return "R6 R11 R3";
    endfunction

    task automatic chk_obs(string tag, obs_t act, obs_t exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_val(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_txn(bit wr, logic [DW-1:0] addr, logic [DW-1:0] wd,
                           logic [DW-1:0] rd, logic [BEW-1:0] be,
                           int a, int e, int b, int gdelay, bit keep, int abort_at);
        int  cnt;
        int  holdk;
        bit  acc;
        cmd_write = wr; cmd_addr = addr; cmd_wdata = wd; cmd_be = be;
        cfg_alapse = LW'(a); cfg_elapse = LW'(e); cfg_blapse = LW'(b);
        bus_ad_in = rd;
        cmd_valid = 1;
        cnt = 0;
        forever begin
            acc = cmd_ready;
            if (bus_req_n) cnt++;
            @(negedge clk);
            if (acc) break;
        end
        cmd_valid = 0;
        // R11: scramble the stretch inputs after acceptance
        cfg_alapse = LW'($urandom); cfg_elapse = LW'($urandom); cfg_blapse = LW'($urandom);
        if (chain) chk_val("R9 request gap", DW'(cnt), DW'(1 + prev_b));
        chk_val("R9 request asserted", DW'(bus_req_n), DW'(0));
        if (bus_gnt_n) begin
            chk_val("R1 undriven while waiting", DW'({bus_cmd_oe, bus_gack_oe, bus_ad_oe}), DW'(0));
            for (int i = 0; i < gdelay; i++) @(negedge clk);
            bus_gnt_n = 0;
        end else begin
            chk_val("R8 parked while requesting", DW'({bus_cmd_oe, bus_as_n, bus_ad_oe}), DW'(3'b110));
        end
        holdk = wr ? 6 + a + e : 5 + a + e;
        for (int k = 1; k <= holdk + 1; k++) begin
            @(negedge clk);
            chk_obs(phase_tag(k, a, e, wr), sample(), expect_at(k, a, e, wr, addr, wd, be));
            if (k == holdk && !wr) chk_val("R6 read data", rdata, rd);
            if (k == abort_at) begin
                bus_gnt_n = 1;
                @(negedge clk);
                chk_obs("R10 abort release", sample(), released(k < holdk));
                for (int j = 0; j < 3; j++) begin
                    @(negedge clk);
                    chk_obs("R10 no reissue", sample(), released(1'b0));
                end
                prev_b = b;
                chain = 0;
                return;
            end
        end
        prev_b = b;
        if (keep) begin
            chain = 1;
        end else begin
            bus_gnt_n = 1;
            @(negedge clk);
            chk_obs("R8 park ends", sample(), released(1'b0));
            chain = 0;
        end
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; cmd_valid = 0; cmd_write = 0; cmd_addr = '0; cmd_wdata = '0;
        cmd_be = '0; cfg_alapse = '0; cfg_elapse = '0; cfg_blapse = '0;
        bus_gnt_n = 1; bus_ad_in = '0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk_obs("R1 reset pins", sample(), released(1'b0));
        chk_val("R1 ready after reset", DW'(cmd_ready), DW'(1));

        // Directed: minimum timing write, then stretched read
        run_txn(1, 32'h1000_0004, 32'hDEAD_BEEF, 32'h0, 4'b1111, 0, 0, 0, 2, 0, 0);
        run_txn(0, 32'h2000_0010, 32'h0, 32'hCAFE_F00D, 4'b0101, 3, 2, 0, 0, 0, 0);

        // Parked chain with request gaps (R8 R9)
        run_txn(1, 32'h3000_0000, 32'h1234_5678, 32'h0, 4'b0011, 1, 1, 3, 1, 1, 0);
        run_txn(0, 32'h3000_0008, 32'h0, 32'h8765_4321, 4'b1000, 0, 4, 0, 0, 1, 0);
        run_txn(1, 32'h3000_000C, 32'hA5A5_5A5A, 32'h0, 4'b1100, 15, 15, 15, 0, 1, 0);
        run_txn(0, 32'h3000_0010, 32'h0, 32'h0F0F_F0F0, 4'b1111, 0, 0, 0, 0, 0, 0);

        // Aborts (R10): mid data strobe on a write, during address on a read, at hold
        run_txn(1, 32'h4000_0000, 32'h5555_AAAA, 32'h0, 4'b1111, 2, 5, 1, 1, 0, 7);
        run_txn(0, 32'h4000_0004, 32'h0, 32'h1111_2222, 4'b1111, 4, 0, 0, 0, 0, 3);
        run_txn(0, 32'h4000_0008, 32'h0, 32'h3333_4444, 4'b0001, 0, 0, 2, 0, 0, 5);

        // Constrained random mix
        for (int t = 0; t < 60; t++) begin
            bit wr;
            int a, e, b, holdk, ab;
            wr = 1'($urandom);
            a = int'($urandom % 16); e = int'($urandom % 16); b = int'($urandom % 16);
            holdk = wr ? 6 + a + e : 5 + a + e;
            ab = (($urandom % 6) == 0) ? 1 + int'($urandom % holdk) : 0;
            run_txn(wr, $urandom, $urandom, $urandom, BEW'($urandom), a, e, b,
                    int'($urandom % 4), 1'($urandom), ab);
        end

        if (chain) begin
            bus_gnt_n = 1;
            @(negedge clk);
            chk_obs("R8 final park ends", sample(), released(1'b0));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule